// File: doc/BRIEF.md
# APB Pin Controller with Interrupt Detection

This block drives and samples 32 general-purpose pins from a register bus in the APB style. Software sets and reads an output value and a per-pin direction. Software can also set or clear chosen output bits in one write, with no read-modify-write. Each pin's input passes through a two-flop synchroniser and can be read back. The block also stores three pad-configuration words (bypass, pull enable, pull select) for the pad ring and reads them back, with no other effect.

Every pin can raise an interrupt. Three configuration bits per pin pick the sensing: level or edge, the active polarity, and a both-edge option for edge sensing. Edge events are latched until a write-one-to-clear acknowledge removes them. Level events follow the input while it is active. A raw status word shows pending pins that are enabled, and a masked status word removes the masked pins from it. The single interrupt output is a registered OR of the masked status.

A shared prescaler divides the bus clock to make a sampling tick for a debounce filter. The filter acts only on pins that have both debounce and interrupt enabled.

Top module: `apb_pin_ctrl`

## Requirements
- R1: Writes take effect on the access-phase cycle (psel, penable and pwrite high) and complete with no wait states. Word offsets: 0x00 output value, 0x04 synchronised input, 0x08 direction, 0x0C bypass, 0x10 set, 0x14 clear, 0x18 pull enable, 0x1C pull select, 0x20 interrupt enable, 0x24 raw status, 0x28 masked status, 0x2C mask, 0x30 acknowledge, 0x34 sense mode, 0x38 both-edge, 0x3C polarity, 0x40 debounce enable, 0x44 prescale. The bypass and pull words read back what was written. The set, clear and acknowledge offsets, and all unmapped offsets, read as zero.
- R2: A write to 0x10 sets each output bit written as 1. A write to 0x14 clears each output bit written as 1. Bits written as 0 keep their value in both cases.
- R3: pinOut carries the output register. pinOutEn carries the direction register, where 1 means the pin drives.
- R4: pinIn is captured by two flops, and 0x04 shows the value that was on the pins two clock edges earlier.
- R5: With a sense bit of 0 (edge sensing) and a both-edge bit of 0, a polarity bit of 0 latches rising edges and a polarity bit of 1 latches falling edges. The opposite edge latches nothing.
- R6: With edge sensing and a both-edge bit of 1, rising and falling edges both latch, whatever the polarity bit holds.
- R7: With a sense bit of 1 (level sensing), status is set while the input is high (polarity 0) or low (polarity 1). The status follows the input, and an acknowledge write does not remove it.
- R8: Writing 1 to a bit of 0x30 removes that pin's latched edge status. Bits written as 0 are untouched.
- R9: A pin whose interrupt-enable bit is 0 neither latches nor reports status.
- R10: Masked status equals raw status with the pins whose mask bit is 1 removed. irqOut is the registered OR of the masked status, so a masked pin still shows in raw status but not on irqOut.
- R11: The prescale register holds 24 bits, and the upper bits of a write are dropped. A value of N>1 gives one tick every N clocks. A value of 0 or 1 gives a tick on every clock.
- R12: A pin with both debounce and interrupt enabled changes its filtered value only when two consecutive ticks sample the same new level. A shorter pulse is rejected, while a pin without debounce passes the same pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address; bits 7:2 pick the word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pinIn | input | 32 | Asynchronous pin inputs |
| pinOut | output | 32 | Output values toward the pads |
| pinOutEn | output | 32 | Per-pin output enable toward the pads |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the bus follows the two-phase protocol, with setup before access and each access lasting one cycle. They also assume that pinIn changes at most once between edges. The bench meets this by driving every bus and pin input on the falling clock edge. It holds each access for exactly one setup and one access cycle, and it waits several cycles after every pin change before it reads status. So the synchroniser depth and the registered interrupt output are always settled when a value is sampled. In the debounce tests, each pin is held for a known number of cycles that is either clearly below or clearly above two tick periods, so that the result does not hinge on the phase of the tick.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
  parameter int PINS   = 32;
  parameter int PRE_W  = 24;
  parameter int ADDR_W = 8;
  localparam int IDX_W = ADDR_W - 2;

  typedef enum logic [IDX_W-1:0] {
    REG_OUT     = 0,
    REG_IN      = 1,
    REG_DIR     = 2,
    REG_BYPASS  = 3,
    REG_SET     = 4,
    REG_CLR     = 5,
    REG_PULLEN  = 6,
    REG_PULLSEL = 7,
    REG_IEN     = 8,
    REG_RAW     = 9,
    REG_MST     = 10,
    REG_MASK    = 11,
    REG_ACK     = 12,
    REG_SENSE   = 13,
    REG_BOTH    = 14,
    REG_POL     = 15,
    REG_DEBEN   = 16,
    REG_PRESC   = 17
  } regIdx_e;

  typedef struct packed {
    logic [PINS-1:0]  intEn;
    logic [PINS-1:0]  intMask;
    logic [PINS-1:0]  senseLevel;
    logic [PINS-1:0]  bothEdge;
    logic [PINS-1:0]  activeLow;
    logic [PINS-1:0]  debEn;
    logic [PRE_W-1:0] prescale;
  } cfg_t;

  typedef struct packed {
    logic            ackWr;
    logic [PINS-1:0] ackBits;
  } strobe_t;
endpackage

// File: rtl/pin_ctrl_regs.sv
module pin_ctrl_regs
  import pin_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [PINS-1:0]   pwdata,
  output logic [PINS-1:0]   prdata,
  input  logic [PINS-1:0]   inData,
  input  logic [PINS-1:0]   rawStat,
  input  logic [PINS-1:0]   maskStat,
  output cfg_t              cfg,
  output strobe_t           strb,
  output logic [PINS-1:0]   outData,
  output logic [PINS-1:0]   dirReg
);
  logic             wrEn;
  logic [IDX_W-1:0] wordIdx;
  logic [PINS-1:0]  bypassReg, pullEnReg, pullSelReg;

  assign wrEn    = psel & penable & pwrite;
  assign wordIdx = paddr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData    <= '0;
      dirReg     <= '0;
      bypassReg  <= '0;
      pullEnReg  <= '0;
      pullSelReg <= '0;
      cfg        <= '0;
    end else if (wrEn) begin
      case (wordIdx)
        REG_OUT:     outData        <= pwdata;
        REG_SET:     outData        <= outData | pwdata;
        REG_CLR:     outData        <= outData & ~pwdata;
        REG_DIR:     dirReg         <= pwdata;
        REG_BYPASS:  bypassReg      <= pwdata;
        REG_PULLEN:  pullEnReg      <= pwdata;
        REG_PULLSEL: pullSelReg     <= pwdata;
        REG_IEN:     cfg.intEn      <= pwdata;
        REG_MASK:    cfg.intMask    <= pwdata;
        REG_SENSE:   cfg.senseLevel <= pwdata;
        REG_BOTH:    cfg.bothEdge   <= pwdata;
        REG_POL:     cfg.activeLow  <= pwdata;
        REG_DEBEN:   cfg.debEn      <= pwdata;
        REG_PRESC:   cfg.prescale   <= pwdata[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.ackWr   = wrEn && (wordIdx == REG_ACK);
    strb.ackBits = pwdata;
  end

  always_comb begin
    prdata = '0;
    case (wordIdx)
      REG_OUT:     prdata = outData;
      REG_IN:      prdata = inData;
      REG_DIR:     prdata = dirReg;
      REG_BYPASS:  prdata = bypassReg;
      REG_PULLEN:  prdata = pullEnReg;
      REG_PULLSEL: prdata = pullSelReg;
      REG_IEN:     prdata = cfg.intEn;
      REG_RAW:     prdata = rawStat;
      REG_MST:     prdata = maskStat;
      REG_MASK:    prdata = cfg.intMask;
      REG_SENSE:   prdata = cfg.senseLevel;
      REG_BOTH:    prdata = cfg.bothEdge;
      REG_POL:     prdata = cfg.activeLow;
      REG_DEBEN:   prdata = cfg.debEn;
      REG_PRESC:   prdata = {{(PINS-PRE_W){1'b0}}, cfg.prescale};
      default:     prdata = '0;
    endcase
  end

  // R2: the set port only adds ones to the output register
  assert_set_merges_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wordIdx == REG_SET) |=> (outData == ($past(outData) | $past(pwdata))));

  // R2: the clear port only removes ones from the output register
  assert_clr_removes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wordIdx == REG_CLR) |=> (outData == ($past(outData) & ~$past(pwdata))));

  // R1: without a bus write the output register holds its value
  assert_out_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(outData));
endmodule

// File: rtl/pin_ctrl_core.sv
module pin_ctrl_core
  import pin_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] pinIn,
  input  cfg_t            cfg,
  input  strobe_t         strb,
  output logic [PINS-1:0] inData,
  output logic [PINS-1:0] rawStat,
  output logic [PINS-1:0] maskStat,
  output logic            irqOut
);
  logic [PINS-1:0]  syncA, syncB;
  logic [PINS-1:0]  filtVec, liveVec, prevLive;
  logic [PINS-1:0]  riseVec, fallVec, edgeHit, levelHit, ackVec, edgeLatch;
  logic [PRE_W-1:0] preCnt;
  logic             tick;

  // two-flop input capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end
  assign inData = syncB;

  // shared sampling tick for the debounce filters
  assign tick = (cfg.prescale <= PRE_W'(1)) || (preCnt >= cfg.prescale - PRE_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + PRE_W'(1);
  end

  // per-pin filter: accept a level once two consecutive ticks agree
  for (genvar g = 0; g < PINS; g++) begin : gPinFilt
    logic sampleQ, filtQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sampleQ <= 1'b0;
        filtQ   <= 1'b0;
      end else if (tick) begin
        sampleQ <= syncB[g];
        if (syncB[g] == sampleQ) filtQ <= syncB[g];
      end
    end
    assign filtVec[g] = filtQ;
    assign liveVec[g] = (cfg.debEn[g] & cfg.intEn[g]) ? filtQ : syncB[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLive <= '0;
    else       prevLive <= liveVec;
  end

  assign riseVec = liveVec & ~prevLive;
  assign fallVec = ~liveVec & prevLive;

  always_comb begin
    edgeHit  = ~cfg.senseLevel & cfg.intEn &
               ((cfg.bothEdge & (riseVec | fallVec)) |
                (~cfg.bothEdge & ~cfg.activeLow & riseVec) |
                (~cfg.bothEdge & cfg.activeLow & fallVec));
    levelHit = cfg.senseLevel & cfg.intEn & (liveVec ^ cfg.activeLow);
    ackVec   = strb.ackWr ? strb.ackBits : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeLatch <= '0;
    else       edgeLatch <= ((edgeLatch & ~ackVec) | edgeHit) & cfg.intEn;
  end

  assign rawStat  = ((edgeLatch & ~cfg.senseLevel) | levelHit) & cfg.intEn;
  assign maskStat = rawStat & ~cfg.intMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |maskStat;
  end

  // R9: a latch bit only appears for a pin that was enabled the cycle before
  assert_latch_enabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((edgeLatch & ~$past(edgeLatch) & ~$past(cfg.intEn)) == '0));

  // R8: an acknowledged bit with no new event is gone the next cycle
  assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((edgeLatch & $past(ackVec) & ~$past(edgeHit)) == '0));

  // R10: with every pin masked the request output stays low
  assert_all_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (&$past(cfg.intMask)) |-> !irqOut);

  // R11: a divider above one never yields back-to-back ticks
  assert_tick_spacing_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.prescale > PRE_W'(1) && $past(cfg.prescale) == cfg.prescale && $past(tick)) |-> !tick);

  // R12: filtered values move only on a tick
  assert_filter_on_tick_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(tick) |-> (filtVec == $past(filtVec)));
endmodule

// File: rtl/apb_pin_ctrl.sv
module apb_pin_ctrl
  import pin_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [PINS-1:0]   pwdata,
  output logic [PINS-1:0]   prdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOutEn,
  output logic              irqOut
);
  cfg_t            cfg;
  strobe_t         strb;
  logic [PINS-1:0] inData, rawStat, maskStat;

  pin_ctrl_regs i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .inData   (inData),
    .rawStat  (rawStat),
    .maskStat (maskStat),
    .cfg      (cfg),
    .strb     (strb),
    .outData  (pinOut),
    .dirReg   (pinOutEn)
  );

  pin_ctrl_core i_core (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .cfg      (cfg),
    .strb     (strb),
    .inData   (inData),
    .rawStat  (rawStat),
    .maskStat (maskStat),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/test_apb_pin_ctrl.sv
module test_apb_pin_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOutEn;
  logic        irqOut;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  apb_pin_ctrl i_apb_pin_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  // vector: {sense, both, polarity, start level, end level, expected status}
  localparam logic [5:0] VECS [10] = '{
    6'b000011, 6'b000100, 6'b001101, 6'b001010, 6'b010011,
    6'b011101, 6'b100011, 6'b100100, 6'b101101, 6'b101010
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);

    // reset state
    busRead(8'h00, rd); check("R1 reset output", rd, 32'h0);
    busRead(8'h24, rd); check("R9 reset raw", rd, 32'h0);
    check("R10 reset irq", {31'b0, irqOut}, 32'h0);
    check("R3 reset enables", pinOutEn, 32'h0);

    // register map, storage and unmapped reads (R1)
    busWrite(8'h0C, 32'hA5A5_0001); busRead(8'h0C, rd); check("R1 bypass", rd, 32'hA5A5_0001);
    busWrite(8'h18, 32'h1234_5678); busRead(8'h18, rd); check("R1 pull enable", rd, 32'h1234_5678);
    busWrite(8'h1C, 32'hFFFF_0000); busRead(8'h1C, rd); check("R1 pull select", rd, 32'hFFFF_0000);
    busRead(8'h48, rd); check("R1 unmapped", rd, 32'h0);
    busRead(8'h10, rd); check("R1 set port reads zero", rd, 32'h0);

    // set and clear ports (R2, R3)
    busWrite(8'h00, 32'h0000_00F0);
    busWrite(8'h10, 32'h0000_000F);
    busRead(8'h00, rd); check("R2 set", rd, 32'h0000_00FF);
    busWrite(8'h14, 32'h0000_0030);
    busRead(8'h00, rd); check("R2 clear", rd, 32'h0000_00CF);
    check("R3 pinOut", pinOut, 32'h0000_00CF);
    busWrite(8'h08, 32'h8000_00FF);
    check("R3 direction", pinOutEn, 32'h8000_00FF);

    // input capture (R4)
    pinIn = 32'hDEAD_BEEF;
    waitCyc(3);
    busRead(8'h04, rd); check("R4 input", rd, 32'hDEAD_BEEF);
    pinIn = '0;
    waitCyc(3);

    // table of sensing modes on pin 3
    for (int i = 0; i < 10; i++) begin
      logic [5:0] v;
      string req;
      v = VECS[i];
      req = v[5] ? "R7 level vector" : (v[4] ? "R6 both-edge vector" : "R5 edge vector");
      busWrite(8'h20, 32'h0);
      busWrite(8'h34, {28'b0, v[5], 3'b0});
      busWrite(8'h38, {28'b0, v[4], 3'b0});
      busWrite(8'h3C, {28'b0, v[3], 3'b0});
      pinIn[3] = v[2];
      waitCyc(5);
      busWrite(8'h20, 32'h8);
      busWrite(8'h30, 32'h8);
      pinIn[3] = v[1];
      waitCyc(5);
      busRead(8'h24, rd);
      check(req, {31'b0, rd[3]}, {31'b0, v[0]});
      busWrite(8'h20, 32'h0);
      pinIn[3] = 1'b0;
      waitCyc(3);
    end

    // all pins back to rising-edge sensing
    busWrite(8'h34, 32'h0); busWrite(8'h38, 32'h0); busWrite(8'h3C, 32'h0);

    // disabled pins do not latch (R9)
    pinIn[0] = 1'b1; waitCyc(5);
    busWrite(8'h20, 32'h1);
    busRead(8'h24, rd); check("R9 disabled edge not latched", rd, 32'h0);

    // mask and acknowledge (R10, R8)
    busWrite(8'h2C, 32'h1);
    pinIn[0] = 1'b0; waitCyc(3);
    pinIn[0] = 1'b1; waitCyc(5);
    busRead(8'h24, rd); check("R10 raw with mask", rd, 32'h1);
    busRead(8'h28, rd); check("R10 masked status", rd, 32'h0);
    check("R10 irq masked", {31'b0, irqOut}, 32'h0);
    busWrite(8'h2C, 32'h0);
    waitCyc(2);
    busRead(8'h28, rd); check("R10 unmasked status", rd, 32'h1);
    check("R10 irq unmasked", {31'b0, irqOut}, 32'h1);
    busWrite(8'h30, 32'hFFFF_FFFE);
    busRead(8'h24, rd); check("R8 zero bits untouched", rd, 32'h1);
    busWrite(8'h30, 32'h1);
    waitCyc(2);
    busRead(8'h24, rd); check("R8 acknowledge", rd, 32'h0);
    check("R10 irq after ack", {31'b0, irqOut}, 32'h0);

    // level status ignores acknowledge (R7)
    busWrite(8'h34, 32'h2);
    busWrite(8'h20, 32'h3);
    pinIn[1] = 1'b1; waitCyc(5);
    busWrite(8'h30, 32'hFFFF_FFFF);
    busRead(8'h24, rd); check("R7 level survives ack", rd & 32'h2, 32'h2);
    pinIn[1] = 1'b0; waitCyc(5);
    busRead(8'h24, rd); check("R7 level follows input", rd & 32'h2, 32'h0);
    busWrite(8'h20, 32'h0); busWrite(8'h34, 32'h0);
    pinIn = '0; waitCyc(3);

    // prescale width (R11)
    busWrite(8'h44, 32'hFFFF_FFFF);
    busRead(8'h44, rd); check("R11 prescale width", rd, 32'h00FF_FFFF);

    // debounce with divider 10: pin 5 filtered, pin 6 not (R12)
    busWrite(8'h44, 32'd10);
    busWrite(8'h40, 32'h20);
    busWrite(8'h20, 32'h60);
    waitCyc(30);
    busWrite(8'h30, 32'hFFFF_FFFF);
    pinIn[6:5] = 2'b11; waitCyc(2);
    pinIn[6:5] = 2'b00; waitCyc(40);
    busRead(8'h24, rd); check("R12 short pulse filtered", rd, 32'h40);
    busWrite(8'h30, 32'hFFFF_FFFF);
    pinIn[5] = 1'b1; waitCyc(40);
    busRead(8'h24, rd); check("R12 steady level passes", rd, 32'h20);
    pinIn[5] = 1'b0; waitCyc(40);
    busWrite(8'h30, 32'hFFFF_FFFF);

    // divider 0 ticks every clock (R11)
    busWrite(8'h44, 32'd0);
    waitCyc(5);
    busWrite(8'h30, 32'hFFFF_FFFF);
    pinIn[5] = 1'b1; waitCyc(1);
    pinIn[5] = 1'b0; waitCyc(8);
    busRead(8'h24, rd); check("R11 one-clock pulse rejected", rd, 32'h0);
    pinIn[5] = 1'b1; waitCyc(4);
    pinIn[5] = 1'b0; waitCyc(8);
    busRead(8'h24, rd); check("R11 four-clock pulse accepted", rd, 32'h20);

    done = 1'b1;
    finishRun();
  end
endmodule